// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a PS/2 keyboard receiver and takes the received byte stream one byte at a time. It turns prefix sequences into single key events. Each event carries a scan code, an extended flag, a release flag and a flag for the Pause key. Bytes that are keyboard replies (acknowledge, echo, self-test result, resend, error) are kept away from the key parser. The acknowledge byte is used to pace the host-to-keyboard LED update.

The block keeps its own record of which CTRL and ALT keys are held and of the three lock states. It toggles a lock on a fresh press of the lock key and then sends the two-byte LED update to a byte transmitter. While only ALT is held, typed decimal digits build a byte. While only CTRL is held, typed hex digits build a byte. Either byte is emitted when that modifier is fully released. A DEL press while both CTRL and ALT are held raises a reset output for a fixed number of cycles.

Top module: `kbd_event_decoder`

## Requirements
- R1: A scan code received with no prefix gives a press event with ev_break=0. The byte F0 followed by a code gives a release event with ev_break=1. ev_valid is high for one cycle, in the cycle after the last byte of the sequence.
- R2: E0 followed by a code gives an extended press with ev_ext=1. A release of an extended key arrives as E0, F0, code and gives ev_ext=1, ev_break=1.
- R3: The eight-byte sequence E1,14,77,E1,F0,14,F0,77 gives exactly one event, with ev_pause=1, ev_code=E1, ev_ext=0 and ev_break=0. None of its bytes gives any other event.
- R4: A byte that does not fit a partial prefix sequence drops that sequence and returns the parser to idle. The dropping byte gives no event. Examples: E0 or E1 after E0; E0, E1 or F0 after F0 or after E0,F0; a wrong byte inside the Pause sequence.
- R5: Received bytes AA, FA, EE, FE, 00 and FF never give an event. They leave any partial prefix sequence intact.
- R6: A press of 7E, 77 or 58 (not extended) toggles Scroll, Num or Caps Lock respectively. A repeated press of the same key with no release in between does not toggle again. lock_leds bit0 is Scroll, bit1 is Num and bit2 is Caps.
- R7: Each lock toggle starts an LED update. tx_valid pulses with ED in the same cycle that lock_leds changes. After a received FA, tx_valid pulses with {5'b0, lock_leds}. A second FA ends the exchange. Toggles during an exchange queue one more complete exchange.
- R8: ctrl_held is high while left CTRL (14) or right CTRL (E0 14) is pressed. alt_held is high while left ALT (11) or right ALT (E0 11) is pressed.
- R9: While only ALT is held, non-extended digit presses accumulate as value*10+digit, modulo 256. The digits are the top-row codes 45,16,1E,26,25,2E,36,3D,3E,46 and the keypad codes 70,69,72,7A,6B,73,74,6C,75,7D for 0 to 9. When the last ALT key is released, num_valid pulses for one cycle with the value, if at least one digit was entered. Hex letters are ignored in this mode.
- R10: While only CTRL is held, the digit codes and the letters 1C,32,21,23,24,2B (A to F) shift in as nibbles, and the last two nibbles are kept. When the last CTRL key is released, num_valid pulses with that byte. Digits typed while both or neither modifier is held are ignored.
- R11: A press of 71 (extended or not) while ctrl_held and alt_held are both high drives sys_reset high for RST_CYCLES cycles, starting one cycle after the event. A DEL press without both modifiers does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ev_valid | output | 1 | Key event strobe |
| ev_code | output | 8 | Event scan code |
| ev_ext | output | 1 | Event is an extended key |
| ev_break | output | 1 | Event is a release |
| ev_pause | output | 1 | Event is the Pause key |
| ctrl_held | output | 1 | A CTRL key is held |
| alt_held | output | 1 | An ALT key is held |
| lock_leds | output | 3 | Lock states {caps, num, scroll} |
| tx_valid | output | 1 | Byte to transmitter strobe |
| tx_byte | output | 8 | Byte to transmitter |
| num_valid | output | 1 | Numeric entry result strobe |
| num_byte | output | 8 | Numeric entry result |
| sys_reset | output | 1 | Reset request pulse |

## Verification
Some properties are checked by assertions on every cycle. An event always follows a parsed byte, and a Pause event always closes on 77. A held lock key never flips its LED bit on repeat. A numeric result appears only after a release event. LED data bytes leave bits 7 to 3 at zero and follow the ED command. sys_reset only rises with both modifiers held. Other behaviour can only be shown by the bench scenarios, against its reference model: the dropping of a broken prefix, reply bytes inside a prefix, the queued second LED exchange, decimal wrap, keeping the last two hex nibbles, and the exact length of the reset pulse.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] B_EXT     = 8'hE0;
  localparam logic [7:0] B_BRK     = 8'hF0;
  localparam logic [7:0] B_PAUSE   = 8'hE1;
  localparam logic [7:0] B_ACK     = 8'hFA;
  localparam logic [7:0] B_LEDCMD  = 8'hED;
  localparam logic [7:0] KC_DEL    = 8'h71;
  localparam int         PAUSE_LEN = 8;
  localparam int         PIDX_W    = $clog2(PAUSE_LEN);

  typedef enum logic [2:0] {P_IDLE, P_E0, P_F0, P_E0F0, P_PAUSE} pstate_t;
  typedef enum logic [1:0] {L_IDLE, L_CMD, L_DATA} lstate_t;

  typedef struct packed {
    logic       dec;
    logic       hex;
    logic [3:0] val;
  } digit_t;

  function automatic logic is_response(input logic [7:0] b);
    return (b == 8'hAA) || (b == 8'hFA) || (b == 8'hEE) ||
           (b == 8'hFE) || (b == 8'h00) || (b == 8'hFF);
  endfunction

  function automatic logic is_prefix(input logic [7:0] b);
    return (b == B_EXT) || (b == B_BRK) || (b == B_PAUSE);
  endfunction

  // expected Pause byte at positions 1..7 (position 0 is the opening E1)
  function automatic logic [7:0] pause_byte(input logic [PIDX_W-1:0] idx);
    case (idx)
      3'd1, 3'd5: return 8'h14;
      3'd2, 3'd7: return 8'h77;
      3'd3:       return 8'hE1;
      3'd4, 3'd6: return 8'hF0;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic digit_t digit_info(input logic [7:0] c);
    digit_t d;
    d = '{dec: 1'b1, hex: 1'b1, val: 4'd0};
    case (c)
      8'h45, 8'h70: d.val = 4'd0;
      8'h16, 8'h69: d.val = 4'd1;
      8'h1E, 8'h72: d.val = 4'd2;
      8'h26, 8'h7A: d.val = 4'd3;
      8'h25, 8'h6B: d.val = 4'd4;
      8'h2E, 8'h73: d.val = 4'd5;
      8'h36, 8'h74: d.val = 4'd6;
      8'h3D, 8'h6C: d.val = 4'd7;
      8'h3E, 8'h75: d.val = 4'd8;
      8'h46, 8'h7D: d.val = 4'd9;
      8'h1C: d = '{dec: 1'b0, hex: 1'b1, val: 4'hA};
      8'h32: d = '{dec: 1'b0, hex: 1'b1, val: 4'hB};
      8'h21: d = '{dec: 1'b0, hex: 1'b1, val: 4'hC};
      8'h23: d = '{dec: 1'b0, hex: 1'b1, val: 4'hD};
      8'h24: d = '{dec: 1'b0, hex: 1'b1, val: 4'hE};
      8'h2B: d = '{dec: 1'b0, hex: 1'b1, val: 4'hF};
      default: d = '{dec: 1'b0, hex: 1'b0, val: 4'd0};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/kbd_seq_parser.sv
module kbd_seq_parser
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       ev_ext,
  output logic       ev_break,
  output logic       ev_pause
);
  pstate_t           st_q, st_d;
  logic [PIDX_W-1:0] idx_q, idx_d;
  logic              emit, c_ext, c_brk, c_pause;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    emit    = 1'b0;
    c_ext   = 1'b0;
    c_brk   = 1'b0;
    c_pause = 1'b0;
    if (byte_valid) begin
      case (st_q)
        P_IDLE: begin
          if (byte_in == B_EXT)        st_d = P_E0;
          else if (byte_in == B_BRK)   st_d = P_F0;
          else if (byte_in == B_PAUSE) begin st_d = P_PAUSE; idx_d = PIDX_W'(1); end
          else                         emit = 1'b1;
        end
        P_E0: begin
          st_d = P_IDLE;
          if (byte_in == B_BRK)          st_d = P_E0F0;
          else if (!is_prefix(byte_in)) begin emit = 1'b1; c_ext = 1'b1; end
        end
        P_F0: begin
          st_d = P_IDLE;
          if (!is_prefix(byte_in)) begin emit = 1'b1; c_brk = 1'b1; end
        end
        P_E0F0: begin
          st_d = P_IDLE;
          if (!is_prefix(byte_in)) begin emit = 1'b1; c_ext = 1'b1; c_brk = 1'b1; end
        end
        P_PAUSE: begin
          if (byte_in != pause_byte(idx_q))         st_d = P_IDLE;
          else if (idx_q == PIDX_W'(PAUSE_LEN - 1)) begin
            st_d = P_IDLE; emit = 1'b1; c_pause = 1'b1;
          end
          else                                      idx_d = idx_q + 1'b1;
        end
        default: st_d = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= P_IDLE;
      idx_q    <= '0;
      ev_valid <= 1'b0;
      ev_code  <= '0;
      ev_ext   <= 1'b0;
      ev_break <= 1'b0;
      ev_pause <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      ev_valid <= emit;
      if (emit) begin
        ev_code  <= c_pause ? B_PAUSE : byte_in;
        ev_ext   <= c_ext;
        ev_break <= c_brk;
        ev_pause <= c_pause;
      end
    end
  end

  assert_event_after_byte_R1: assert property (@(posedge clk) disable iff (!srst_n)
    ev_valid |-> $past(byte_valid));
  assert_pause_closes_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (ev_valid && ev_pause) |-> ($past(byte_in) == 8'h77 && !ev_break && !ev_ext));
endmodule

// File: rtl/kbd_led_link.sv
module kbd_led_link
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       req,
  input  logic       ack,
  input  logic [2:0] leds,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  lstate_t    st_q, st_d;
  logic       pend_q, pend_d, send;
  logic [7:0] byte_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    send   = 1'b0;
    byte_d = tx_byte;
    case (st_q)
      L_IDLE: if (req || pend_q) begin
        send = 1'b1; byte_d = B_LEDCMD; st_d = L_CMD; pend_d = 1'b0;
      end
      L_CMD: begin
        if (req) pend_d = 1'b1;
        if (ack) begin send = 1'b1; byte_d = {5'b0, leds}; st_d = L_DATA; end
      end
      L_DATA: begin
        if (req) pend_d = 1'b1;
        if (ack) st_d = L_IDLE;
      end
      default: st_d = L_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= L_IDLE;
      pend_q   <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      tx_valid <= send;
      if (send) tx_byte <= byte_d;
    end
  end

  assert_tx_single_pulse_R7: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |=> !tx_valid);
  assert_data_after_cmd_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && st_q == L_DATA) |-> (tx_byte[7:3] == 5'b0 && $past(st_q) == L_CMD));
endmodule

// File: rtl/kbd_num_entry.sv
module kbd_num_entry
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       ev_valid,
  input  logic [7:0] ev_code,
  input  logic       ev_ext,
  input  logic       ev_break,
  input  logic       ctrl_held,
  input  logic       alt_held,
  input  logic       ctrl_fall,
  input  logic       alt_fall,
  output logic       num_valid,
  output logic [7:0] num_byte
);
  logic       active_q, hexmode_q, digit_ok, emit;
  logic [7:0] acc_q, acc_d, base;
  digit_t     dinfo;

  always_comb begin
    dinfo    = digit_info(ev_code);
    digit_ok = ev_valid && !ev_break && !ev_ext && (ctrl_held ^ alt_held) &&
               (alt_held ? dinfo.dec : dinfo.hex);
    emit     = active_q && (hexmode_q ? ctrl_fall : alt_fall);
    base     = active_q ? acc_q : 8'd0;
    acc_d    = acc_q;
    if (digit_ok)
      acc_d = alt_held ? 8'(base * 8'd10 + {4'd0, dinfo.val}) : {base[3:0], dinfo.val};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      active_q  <= 1'b0;
      hexmode_q <= 1'b0;
      acc_q     <= '0;
      num_valid <= 1'b0;
      num_byte  <= '0;
    end else begin
      num_valid <= emit;
      if (emit)          num_byte  <= acc_q;
      if (digit_ok)      hexmode_q <= ctrl_held;
      if (emit)          active_q  <= 1'b0;
      else if (digit_ok) active_q  <= 1'b1;
      acc_q <= acc_d;
    end
  end

  assert_emit_on_release_R9: assert property (@(posedge clk) disable iff (!srst_n)
    num_valid |-> $past(ev_valid && ev_break));
endmodule

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder
  import kbd_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       ev_ext,
  output logic       ev_break,
  output logic       ev_pause,
  output logic       ctrl_held,
  output logic       alt_held,
  output logic [2:0] lock_leds,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       num_valid,
  output logic [7:0] num_byte,
  output logic       sys_reset
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam int NMOD  = 4;
  localparam int NLOCK = 3;
  // modifier slots: 0 left ctrl, 1 right ctrl, 2 left alt, 3 right alt
  localparam logic [7:0] MOD_CODE [NMOD]  = '{8'h14, 8'h14, 8'h11, 8'h11};
  localparam logic       MOD_EXT  [NMOD]  = '{1'b0, 1'b1, 1'b0, 1'b1};
  // lock slots: 0 scroll, 1 num, 2 caps (matches LED bit order)
  localparam logic [7:0] LOCK_CODE [NLOCK] = '{8'h7E, 8'h77, 8'h58};

  logic [1:0]       sync_q;
  logic             srst_n, byte_ok, led_ack, plain_ev, rst_trig;
  logic             ctrl_next, alt_next, ctrl_fall, alt_fall;
  logic [NMOD-1:0]  mod_q, mod_d;
  logic [NLOCK-1:0] lhold_q, lhold_d, ltog, led_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  assign byte_ok = rx_valid && !is_response(rx_byte);
  assign led_ack = rx_valid && (rx_byte == B_ACK);

  kbd_seq_parser u_parser (
    .clk(clk), .srst_n(srst_n), .byte_valid(byte_ok), .byte_in(rx_byte),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_ext(ev_ext),
    .ev_break(ev_break), .ev_pause(ev_pause)
  );

  assign plain_ev = ev_valid && !ev_pause;

  for (genvar gm = 0; gm < NMOD; gm++) begin : g_mod
    assign mod_d[gm] = (plain_ev && ev_code == MOD_CODE[gm] && ev_ext == MOD_EXT[gm])
                       ? !ev_break : mod_q[gm];
  end

  for (genvar gl = 0; gl < NLOCK; gl++) begin : g_lock
    logic hit;
    assign hit         = plain_ev && !ev_ext && ev_code == LOCK_CODE[gl];
    assign ltog[gl]    = hit && !ev_break && !lhold_q[gl];
    assign lhold_d[gl] = hit ? !ev_break : lhold_q[gl];
  end

  assign ctrl_held = mod_q[0] | mod_q[1];
  assign alt_held  = mod_q[2] | mod_q[3];
  assign ctrl_next = mod_d[0] | mod_d[1];
  assign alt_next  = mod_d[2] | mod_d[3];
  assign ctrl_fall = ctrl_held && !ctrl_next;
  assign alt_fall  = alt_held && !alt_next;

  assign rst_trig = plain_ev && !ev_break && ev_code == KC_DEL && ctrl_held && alt_held;
  always_comb begin
    cnt_d = cnt_q;
    if (rst_trig)           cnt_d = CNT_W'(RST_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mod_q   <= '0;
      lhold_q <= '0;
      led_q   <= '0;
      cnt_q   <= '0;
    end else begin
      mod_q   <= mod_d;
      lhold_q <= lhold_d;
      led_q   <= led_q ^ ltog;
      cnt_q   <= cnt_d;
    end
  end

  assign lock_leds = led_q;
  assign sys_reset = (cnt_q != '0);

  kbd_led_link u_led (
    .clk(clk), .srst_n(srst_n), .req(|ltog), .ack(led_ack), .leds(led_q),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  kbd_num_entry u_num (
    .clk(clk), .srst_n(srst_n), .ev_valid(plain_ev), .ev_code(ev_code),
    .ev_ext(ev_ext), .ev_break(ev_break), .ctrl_held(ctrl_held), .alt_held(alt_held),
    .ctrl_fall(ctrl_fall), .alt_fall(alt_fall),
    .num_valid(num_valid), .num_byte(num_byte)
  );

  assert_caps_repeat_holds_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (plain_ev && !ev_break && !ev_ext && ev_code == 8'h58 && lhold_q[2]) |=> $stable(lock_leds[2]));
  assert_reset_needs_combo_R11: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sys_reset) |-> $past(ctrl_held && alt_held));
  assert_led_cmd_on_toggle_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (lock_leds != $past(lock_leds)) |-> (tx_valid || $past(u_led.st_q) != L_IDLE));
endmodule

// File: tb/kbd_event_decoder_tb.sv
`timescale 1ns/1ps
module kbd_event_decoder_tb;
  localparam int RST_CYCLES = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ev_valid, ev_ext, ev_break, ev_pause, ctrl_held, alt_held;
  logic       tx_valid, num_valid, sys_reset;
  logic [7:0] ev_code, tx_byte, num_byte;
  logic [2:0] lock_leds;

  always #2 clk = ~clk;

  kbd_event_decoder #(.RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_ext(ev_ext), .ev_break(ev_break),
    .ev_pause(ev_pause), .ctrl_held(ctrl_held), .alt_held(alt_held),
    .lock_leds(lock_leds), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .num_valid(num_valid), .num_byte(num_byte), .sys_reset(sys_reset)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int pseq [8] = '{'hE1, 'h14, 'h77, 'hE1, 'hF0, 'h14, 'hF0, 'h77};
  int ps, pi;
  bit m_ev, m_ext, m_brk, m_pau; int m_code;
  bit lc, rc, la, ra;
  bit [2:0] m_leds, m_lh;
  int lst; bit lpend, m_txv; int m_txb;
  bit nact, nhex; int nacc; bit m_numv; int m_num;
  int mcnt;

  function automatic bit resp(int b);
    return b == 'hAA || b == 'hFA || b == 'hEE || b == 'hFE || b == 'h00 || b == 'hFF;
  endfunction

  function automatic int digit(int c, bit hexok);
    int tr[10] = '{'h45, 'h16, 'h1E, 'h26, 'h25, 'h2E, 'h36, 'h3D, 'h3E, 'h46};
    int kp[10] = '{'h70, 'h69, 'h72, 'h7A, 'h6B, 'h73, 'h74, 'h6C, 'h75, 'h7D};
    int hx[6]  = '{'h1C, 'h32, 'h21, 'h23, 'h24, 'h2B};
    for (int i = 0; i < 10; i++) if (c == tr[i] || c == kp[i]) return i;
    if (hexok) for (int i = 0; i < 6; i++) if (c == hx[i]) return 10 + i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps = 0; pi = 0; m_ev = 0; m_ext = 0; m_brk = 0; m_pau = 0; m_code = 0;
      lc = 0; rc = 0; la = 0; ra = 0; m_leds = 0; m_lh = 0;
      lst = 0; lpend = 0; m_txv = 0; m_txb = 0;
      nact = 0; nhex = 0; nacc = 0; m_numv = 0; m_num = 0; mcnt = 0;
    end else begin
      bit oc, oa, nc, na, req, ack, plain; int d; bit [2:0] oleds;
      plain = m_ev && !m_pau;
      oc = lc | rc; oa = la | ra;
      if (plain && m_code == 'h14) begin if (m_ext) rc = !m_brk; else lc = !m_brk; end
      if (plain && m_code == 'h11) begin if (m_ext) ra = !m_brk; else la = !m_brk; end
      nc = lc | rc; na = la | ra;
      // reset pulse
      if (plain && !m_brk && m_code == 'h71 && oc && oa) mcnt = RST_CYCLES;
      else if (mcnt > 0) mcnt--;
      // numeric entry
      m_numv = 0;
      if (nact && (nhex ? (oc && !nc) : (oa && !na))) begin
        m_numv = 1; m_num = nacc; nact = 0;
      end else if (plain && !m_brk && !m_ext && (oc != oa)) begin
        d = digit(m_code, oc);
        if (d >= 0) begin
          if (!nact) nacc = 0;
          nacc = oa ? (nacc * 10 + d) % 256 : ((nacc % 16) * 16 + d);
          nact = 1; nhex = oc;
        end
      end
      // locks
      oleds = m_leds; req = 0;
      for (int i = 0; i < 3; i++) begin
        int kc; kc = (i == 0) ? 'h7E : (i == 1) ? 'h77 : 'h58;
        if (plain && !m_ext && m_code == kc) begin
          if (!m_brk && !m_lh[i]) begin m_leds[i] = !m_leds[i]; req = 1; end
          m_lh[i] = !m_brk;
        end
      end
      // LED exchange
      ack = rx_valid && rx_byte == 8'hFA;
      m_txv = 0;
      case (lst)
        0: if (req || lpend) begin m_txv = 1; m_txb = 'hED; lst = 1; lpend = 0; end
        1: begin if (req) lpend = 1; if (ack) begin m_txv = 1; m_txb = int'(oleds); lst = 2; end end
        default: begin if (req) lpend = 1; if (ack) lst = 0; end
      endcase
      // parser
      m_ev = 0;
      if (rx_valid && !resp(int'(rx_byte))) begin
        int b; bit pre; b = int'(rx_byte);
        pre = (b == 'hE0 || b == 'hF0 || b == 'hE1);
        case (ps)
          0: if (b == 'hE0) ps = 1; else if (b == 'hF0) ps = 2;
             else if (b == 'hE1) begin ps = 4; pi = 1; end
             else begin m_ev = 1; m_code = b; m_ext = 0; m_brk = 0; m_pau = 0; end
          1: begin ps = 0; if (b == 'hF0) ps = 3;
               else if (!pre) begin m_ev = 1; m_code = b; m_ext = 1; m_brk = 0; m_pau = 0; end end
          2: begin ps = 0; if (!pre) begin m_ev = 1; m_code = b; m_ext = 0; m_brk = 1; m_pau = 0; end end
          3: begin ps = 0; if (!pre) begin m_ev = 1; m_code = b; m_ext = 1; m_brk = 1; m_pau = 0; end end
          default: if (b != pseq[pi]) ps = 0;
                   else if (pi == 7) begin ps = 0; m_ev = 1; m_code = 'hE1; m_ext = 0; m_brk = 0; m_pau = 1; end
                   else pi++;
        endcase
      end
    end
  end

  // per-cycle comparison against the model, plus directed-check capture
  int ev_cnt = 0, last_code = 0, last_ext = 0, last_brk = 0, last_pau = 0;
  int num_cnt = 0, last_num = 0, rst_len = 0;
  int txq[$];
  always @(negedge clk) if (rst_n && !done) begin
    n_checks++;
    if (ev_valid !== m_ev || (m_ev && (ev_code !== 8'(m_code) || ev_ext !== m_ext ||
        ev_break !== m_brk || ev_pause !== m_pau))) begin
      n_fail++;
      $display("FAIL R1 R2 R3 R4 R5 event actual=%0b/%0h expected=%0b/%0h", ev_valid, ev_code, m_ev, m_code);
    end else if (lock_leds !== m_leds) begin
      n_fail++; $display("FAIL R6 leds actual=%0h expected=%0h", lock_leds, m_leds);
    end else if (ctrl_held !== (lc | rc) || alt_held !== (la | ra)) begin
      n_fail++; $display("FAIL R8 mods actual=%0b%0b expected=%0b%0b", ctrl_held, alt_held, lc | rc, la | ra);
    end else if (tx_valid !== m_txv || (m_txv && tx_byte !== 8'(m_txb))) begin
      n_fail++; $display("FAIL R7 tx actual=%0b/%0h expected=%0b/%0h", tx_valid, tx_byte, m_txv, m_txb);
    end else if (num_valid !== m_numv || (m_numv && num_byte !== 8'(m_num))) begin
      n_fail++; $display("FAIL R9 R10 num actual=%0b/%0h expected=%0b/%0h", num_valid, num_byte, m_numv, m_num);
    end else if (sys_reset !== (mcnt != 0)) begin
      n_fail++; $display("FAIL R11 reset actual=%0b expected=%0b", sys_reset, mcnt != 0);
    end
    if (ev_valid) begin
      ev_cnt++; last_code = ev_code; last_ext = ev_ext; last_brk = ev_break; last_pau = ev_pause;
    end
    if (tx_valid) txq.push_back(int'(tx_byte));
    if (num_valid) begin num_cnt++; last_num = num_byte; end
    if (sys_reset) rst_len++;
  end

  task automatic send(input int b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(b);
    @(negedge clk); rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset ev_valid", ev_valid, 0);
    chk("R6 reset leds", lock_leds, 0);
    chk("R11 reset sys_reset", sys_reset, 0);

    send('h1C); chk("R1 make count", ev_cnt, 1); chk("R1 make code", last_code, 'h1C);
    chk("R1 make brk", last_brk, 0);
    send('hF0); send('h1C); chk("R1 break brk", last_brk, 1); chk("R1 break count", ev_cnt, 2);

    send('hE0); send('h75); chk("R2 ext make", last_ext * 2 + last_brk, 2);
    send('hE0); send('hF0); send('h75); chk("R2 ext break", last_ext * 2 + last_brk, 3);

    c0 = ev_cnt;
    send('hF0); send('hE0); chk("R4 dropped prefix no event", ev_cnt, c0);
    send('h75); chk("R4 parser idle afterwards", last_ext * 2 + last_brk, 0);

    c0 = ev_cnt;
    send('hAA); send('h00); chk("R5 responses no event", ev_cnt, c0);
    send('hE0); send('hFE); send('h75); chk("R5 prefix kept across response", last_ext, 1);

    c0 = ev_cnt;
    foreach (pseq[i]) send(pseq[i]);
    chk("R3 pause single event", ev_cnt, c0 + 1); chk("R3 pause flag", last_pau, 1);
    c0 = ev_cnt;
    send('hE1); send('h14); send('h33);
    chk("R4 broken pause no event", ev_cnt, c0);

    txq.delete();
    send('h58); chk("R6 caps on", lock_leds, 3'b100); chk("R7 cmd sent", txq[0], 'hED);
    send('hFA); chk("R7 data byte", txq[1], 'h04);
    send('hFA);
    send('h58); chk("R6 repeat no toggle", lock_leds, 3'b100); chk("R7 no tx on repeat", txq.size(), 2);
    send('hF0); send('h58); send('h58); chk("R6 caps off", lock_leds, 3'b000);
    send('hFA); send('hFA);
    txq.delete();
    send('h7E); send('h77); chk("R6 scroll num", lock_leds, 3'b011);
    send('hFA); send('hFA); send('hFA); send('hFA);
    chk("R7 queued exchange count", txq.size(), 4);
    chk("R7 queued data", txq[3], 'h03);

    send('h14); chk("R8 ctrl left", ctrl_held, 1);
    send('hE0); send('h14); send('hF0); send('h14); chk("R8 ctrl right still", ctrl_held, 1);
    send('hE0); send('hF0); send('h14); chk("R8 ctrl released", ctrl_held, 0);

    send('h11); send('h1E); send('h2E); send('h2E); send('hF0); send('h11);
    chk("R9 alt 255", last_num, 'hFF);
    send('h11); send('h26); send('h45); send('h45); send('hF0); send('h11);
    chk("R9 alt wrap 300", last_num, 'h2C);
    send('h11); send('h1C); send('h69); send('h72); send('hF0); send('h11);
    chk("R9 keypad 12 letter ignored", last_num, 'h0C);
    send('h14); send('h16); send('h1E); send('h1C); send('h32); send('hF0); send('h14);
    chk("R10 ctrl hex AB", last_num, 'hAB);
    c0 = num_cnt;
    send('h16); chk("R10 digit with no modifier", num_cnt, c0);

    rst_len = 0;
    send('h14); send('h71); send('hF0); send('h71); send('hF0); send('h14);
    chk("R11 del without alt", rst_len, 0);
    send('h14); send('h11); send('hE0); send('h71);
    repeat (RST_CYCLES + 4) @(negedge clk);
    #1;
    chk("R11 reset length", rst_len, RST_CYCLES);
    send('hF0); send('h11); send('hF0); send('h14);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule